// File: doc/BRIEF.md
# Collision Backoff Slot Scheduler

After a collision on a shared carrier-sense medium, this block decides how many slot periods the station must wait before it may try to transmit again. It counts those slots on an external slot-period tick. When the count runs out, it raises a single-cycle transmit-permitted pulse.

Two algorithms are available, chosen by a mode input. In random mode, the wait is taken from an on-chip 8-bit pseudo-random shift register when the collision occurs. In deterministic priority mode, the wait follows from a six-bit station slot address and a programmable maximum slot count. Higher addresses go earlier. Address 0 sits out every slot.

The pseudo-random register can be written and read. Writing all ones freezes it. Any other written value restarts the sequence from that value.

Top module: `backoff_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `busy_o` and `tx_ok_o` are 0. The pseudo-random register reads 0x00 during reset.
- R2: When no write is made, the pseudo-random register q advances on every clock to {q[6:0], ~(q[7]^q[5]^q[4]^q[3])}. From 0x00 it therefore continues to 0x01.
- R3: A write loads `prbs_wdata_i`, and the value is visible on `prbs_o` the next cycle. A value of 0xFF then stays 0xFF for as long as no other value is written.
- R4: A `collision_i` high at a clock edge starts a backoff, and `busy_o` is 1 in the following cycle.
- R5: With `det_mode_i`=1 and a slot address a in 1..63, the wait is max_slots − a ticks when max_slots > a, and 0 otherwise.
- R6: With `det_mode_i`=1 and slot address 0, the wait is max_slots + 1 ticks.
- R7: With `det_mode_i`=0, the wait equals the pseudo-random register value at the collision edge, ANDed with the smallest all-ones mask (2^k − 1) that is not below max_slots.
- R8: The countdown moves only on edges where `slot_tick_i` is high. If the collision edge is edge 0 and a tick is present at every edge, then with wait W `tx_ok_o` is high for exactly one cycle after edge W+1. `busy_o` is 0 from that same edge on.
- R9: A collision while a backoff is running reloads the wait and restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| collision_i | input | 1 | Collision event, one cycle |
| slot_tick_i | input | 1 | One pulse per slot period |
| det_mode_i | input | 1 | 1 = deterministic priority, 0 = random |
| slot_addr_i | input | 6 | Station slot address |
| max_slots_i | input | 8 | Programmed maximum slot count |
| prbs_wr_i | input | 1 | Write strobe for the pseudo-random register |
| prbs_wdata_i | input | 8 | Value written to the pseudo-random register |
| busy_o | output | 1 | Backoff in progress |
| tx_ok_o | output | 1 | One-cycle transmit-permitted pulse |
| prbs_o | output | 8 | Pseudo-random register readback |

## Verification
The bench sweeps all 64 slot addresses against several maximum counts, including a count of zero and a count below many addresses. A design that clamped the wait wrongly would wrap to a huge wait, and one that treated address 0 as an ordinary address would let it transmit one slot too early.

Random mode is tried with seeds and limits that land on and between mask boundaries. A mask that is off by one bit, or sampled a cycle late, would give a different slot count.

The all-ones freeze, the restart after a non-frozen write, and the no-tick hold are each watched directly. So are restarts by a second collision. A design that forgot to reload would finish early.

// File: rtl/backoff_sched.sv
module backoff_sched #(
  parameter int ADDR_W = 6,
  parameter int MAX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              collision_i,
  input  logic              slot_tick_i,
  input  logic              det_mode_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [MAX_W-1:0]  max_slots_i,
  input  logic              prbs_wr_i,
  input  logic [7:0]        prbs_wdata_i,
  output logic              busy_o,
  output logic              tx_ok_o,
  output logic [7:0]        prbs_o
);
  localparam int CNT_W = MAX_W + 1;

  logic [7:0]       prbs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, txok_q;

  function automatic logic [MAX_W-1:0] smear(input logic [MAX_W-1:0] v);
    logic [MAX_W-1:0] r;
    r = v;
    for (int i = 0; i < MAX_W; i++) r = r | (r >> 1);
    return r;
  endfunction

  logic [CNT_W-1:0] max_ext, addr_ext, det_wait, rnd_wait, wait_w;

  assign max_ext  = CNT_W'(max_slots_i);
  assign addr_ext = CNT_W'(slot_addr_i);

  always_comb begin
    if (slot_addr_i == '0)
      det_wait = max_ext + 1'b1;
    else if (max_ext > addr_ext)
      det_wait = max_ext - addr_ext;
    else
      det_wait = '0;
  end

  assign rnd_wait = CNT_W'(prbs_q) & CNT_W'(smear(max_slots_i));
  assign wait_w   = det_mode_i ? det_wait : rnd_wait;

  always_ff @(posedge clk) begin
    if (!rst_n)
      prbs_q <= '0;
    else if (prbs_wr_i)
      prbs_q <= prbs_wdata_i;
    else
      prbs_q <= {prbs_q[6:0], ~(prbs_q[7] ^ prbs_q[5] ^ prbs_q[4] ^ prbs_q[3])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      txok_q <= 1'b0;
    end else begin
      txok_q <= 1'b0;
      if (collision_i) begin
        busy_q <= 1'b1;
        cnt_q  <= wait_w;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          txok_q <= 1'b1;
        end else if (slot_tick_i) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign tx_ok_o = txok_q;
  assign prbs_o  = prbs_q;
endmodule

// File: rtl/backoff_sched_chk.sv
module backoff_sched_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             collision,
  input logic             slot_tick,
  input logic             prbs_wr,
  input logic [7:0]       prbs_wdata,
  input logic             busy,
  input logic             tx_ok,
  input logic [7:0]       prbs,
  input logic [CNT_W-1:0] cnt
);
  a_r4_collision_busy: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> busy);
  a_r8_ok_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |-> !busy);
  a_r8_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> !tx_ok);
  a_r8_fall_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_ok);
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !collision && !slot_tick && cnt != '0) |=> $stable(cnt));
  a_r3_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_wr |=> prbs == $past(prbs_wdata));
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (prbs == 8'hFF && !prbs_wr) |=> prbs == 8'hFF);
endmodule

bind backoff_sched backoff_sched_chk #(.CNT_W(MAX_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .collision(collision_i), .slot_tick(slot_tick_i),
  .prbs_wr(prbs_wr_i), .prbs_wdata(prbs_wdata_i), .busy(busy_q),
  .tx_ok(txok_q), .prbs(prbs_q), .cnt(cnt_q)
);

// File: tb/tb_backoff_sched.sv
module tb_backoff_sched;
  logic clk = 0, rst_n = 0;
  logic collision = 0, tick = 1, det = 1, wr = 0;
  logic [5:0] addr = 0;
  logic [7:0] maxs = 0, wdata = 0;
  logic busy, tx_ok;
  logic [7:0] prbs;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  backoff_sched dut (
    .clk(clk), .rst_n(rst_n), .collision_i(collision), .slot_tick_i(tick),
    .det_mode_i(det), .slot_addr_i(addr), .max_slots_i(maxs),
    .prbs_wr_i(wr), .prbs_wdata_i(wdata), .busy_o(busy), .tx_ok_o(tx_ok),
    .prbs_o(prbs));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] q);
    return {q[6:0], ~(q[7] ^ q[5] ^ q[4] ^ q[3])};
  endfunction

  task automatic coll(output logic [7:0] p);
    @(negedge clk); p = prbs; collision = 1;
    @(negedge clk); collision = 0;
    chk(busy === 1'b1, "R4", busy, 1);
  endtask

  task automatic measure(input string req, input int exp);
    int w = -1;
    for (int j = 1; j < 400; j++) begin
      @(negedge clk);
      if (tx_ok === 1'b1) begin
        w = j - 1;
        chk(busy === 1'b0, "R8", busy, 0);
        break;
      end
    end
    chk(w == exp, req, w, exp);
    @(negedge clk);
    chk(tx_ok === 1'b0, "R8", tx_ok, 0);
  endtask

  task automatic wr_prbs(input logic [7:0] v);
    @(negedge clk); wr = 1; wdata = v;
    @(negedge clk); wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] p, prev;
    int m, expw;
    int dmax[4] = '{0, 37, 63, 100};
    int rmax[5] = '{0, 1, 5, 63, 200};
    logic [7:0] seeds[4] = '{8'h00, 8'h5A, 8'hC3, 8'hFF};

    repeat (3) @(negedge clk);
    chk(prbs === 8'h00, "R1", prbs, 0);
    chk(busy === 1'b0, "R1", busy, 0);
    chk(tx_ok === 1'b0, "R1", tx_ok, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && tx_ok === 1'b0, "R1", busy, 0);
    chk(prbs === 8'h01, "R2", prbs, 1);
    prev = prbs;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(prbs === step(prev), "R2", prbs, step(prev));
      prev = prbs;
    end

    wr_prbs(8'hFF);
    chk(prbs === 8'hFF, "R3", prbs, 255);
    repeat (10) @(negedge clk);
    chk(prbs === 8'hFF, "R3", prbs, 255);
    wr_prbs(8'h5A);
    chk(prbs === 8'h5A, "R3", prbs, 8'h5A);
    @(negedge clk);
    chk(prbs === step(8'h5A), "R3", prbs, step(8'h5A));

    det = 1; tick = 1;
    foreach (dmax[k]) begin
      maxs = 8'(dmax[k]);
      for (int a = 0; a < 64; a++) begin
        addr = 6'(a);
        if (a == 0) expw = dmax[k] + 1;
        else expw = (dmax[k] > a) ? dmax[k] - a : 0;
        coll(p);
        measure(a == 0 ? "R6" : "R5", expw);
      end
    end

    maxs = 63; addr = 60; tick = 0;
    coll(p);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(tx_ok === 1'b0 && busy === 1'b1, "R8", tx_ok, 0);
    end
    tick = 1;
    measure("R8", 3);

    addr = 10;
    coll(p);
    repeat (20) @(negedge clk);
    chk(busy === 1'b1, "R9", busy, 1);
    coll(p);
    measure("R9", 53);

    det = 0;
    foreach (seeds[s]) begin
      foreach (rmax[k]) begin
        wr_prbs(seeds[s]);
        maxs = 8'(rmax[k]);
        m = 0;
        while (m < rmax[k]) m = m * 2 + 1;
        coll(p);
        measure("R7", int'(p) & m);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule